// File: doc/BRIEF.md
# Equalizer Sleep and Mute Controller

This block decides when a cable equalizer's analog front end is powered and whether its recovered serial data may leave the chip. It takes a 2-bit sleep policy and a mute bit, both held in a configuration register elsewhere, and a raw carrier-present flag from the signal detector. From these it drives a power-enable for the equalizer and gates the data path.

Three power policies exist: always on, off whenever no carrier is present, and forced off. In the carrier-dependent policy the block waits a programmable number of system clock cycles of continuous carrier absence before it removes power, and the wait restarts whenever the carrier comes back. A returning carrier restores power in the same cycle it is seen. The carrier flag is brought into the clock domain by a two-flop synchronizer. It is then reported two ways: an active-low carrier-detect pin and an active-high status bit for the register file.

The data gate follows a fixed priority. A powered-down equalizer always yields zero data. A powered equalizer yields zero data when muted and passes the input otherwise. The gated data is registered once.

Top module: `eqs_ctrl`

## Requirements
- R1: While and directly after reset, `eq_power_en` is 1 (sleep policy 01, timer cleared), `data_out` is 0, `cd_n` is 1 and `carrier_status` is 0.
- R2: With `sleep_mode` = 2'b00 the equalizer stays powered (`eq_power_en` = 1) whatever the carrier does.
- R3: The reserved code `sleep_mode` = 2'b11 behaves exactly like 2'b00.
- R4: With `sleep_mode` = 2'b10 `eq_power_en` is 0 in the same cycle, carrier present or not.
- R5: With `sleep_mode` = 2'b01, after `carrier_raw` falls (timer previously cleared), `eq_power_en` falls on exactly the (LOSS_DELAY+2)-th rising clock edge: two edges of synchronization plus LOSS_DELAY edges of timing.
- R6: Any synchronized carrier presence clears the loss timer, so a brief carrier pulse during the wait postpones power-down by a full LOSS_DELAY again.
- R7: With `sleep_mode` = 2'b01, `eq_power_en` returns to 1 on the second rising edge after `carrier_raw` rises, with no timer involved.
- R8: `carrier_status` equals `carrier_raw` as it was two rising edges earlier, and `cd_n` is always its inverse (1 = no carrier).
- R9: When powered, `data_out` at each rising edge takes `data_in` if `mute` = 0 and all zeros if `mute` = 1.
- R10: When `eq_power_en` is 0, `data_out` becomes all zeros at the next edge whatever `mute` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_mode | input | 2 | Power policy: 00 on, 01 carrier-dependent, 10 forced off, 11 as 00 |
| mute | input | 1 | 1 forces the data output to zero |
| carrier_raw | input | 1 | Asynchronous carrier-present flag from the detector |
| data_in | input | DATA_W | Recovered data from the equalizer |
| eq_power_en | output | 1 | Equalizer power enable, 1 = powered |
| data_out | output | DATA_W | Gated, registered data |
| cd_n | output | 1 | Carrier detect pin, 0 = carrier present |
| carrier_status | output | 1 | Synchronized carrier flag for the register file, 1 = present |

## Verification
On every cycle the assertions check the fixed policies (always on, forced off), that carrier presence in the carrier-dependent policy always means power, that power only falls after at least two cycles without synchronized carrier, the two-edge synchronizer latency and that nonzero data only leaves when the previous cycle was powered and unmuted. The exact power-down delay of LOSS_DELAY+2 edges, the timer restart after a short carrier pulse and the wake-up latency can only be shown by the bench's timed scenarios. These are measured edge by edge. A sweep over every policy, mute and carrier combination checks the steady-state power and data.

// File: rtl/eqs_pkg.sv
package eqs_pkg;

    typedef enum logic [1:0] {
        SLP_NEVER = 2'b00,
        SLP_AUTO  = 2'b01,
        SLP_FORCE = 2'b10,
        SLP_RSVD  = 2'b11
    } sleep_code_e;

    typedef enum logic [1:0] {
        POL_ON,
        POL_CARRIER,
        POL_OFF
    } power_policy_e;

    typedef struct packed {
        logic carrier;
        logic expired;
    } loss_state_t;

    function automatic power_policy_e decode_sleep(input logic [1:0] code);
        power_policy_e p;
        case (code)
            SLP_AUTO:  p = POL_CARRIER;
            SLP_FORCE: p = POL_OFF;
            default:   p = POL_ON;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/eqs_sync.sv
module eqs_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= 2'b00;
        else     stage_q <= {stage_q[0], async_in};
    end

    assign sync_out = stage_q[1];

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)               age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assert_sync_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/eqs_loss_timer.sv
module eqs_loss_timer #(
    parameter int LOSS_DELAY = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic carrier,
    output logic expired
);
    localparam int CW = $clog2(LOSS_DELAY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOSS_DELAY);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (carrier)       cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LIMIT);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);
    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        carrier |=> !expired);
endmodule

// File: rtl/eqs_power.sv
module eqs_power
    import eqs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  sleep_mode,
    input  loss_state_t loss,
    output logic        power_en
);
    power_policy_e policy;

    always_comb begin
        policy = decode_sleep(sleep_mode);
        case (policy)
            POL_OFF:     power_en = 1'b0;
            POL_CARRIER: power_en = loss.carrier | ~loss.expired;
            default:     power_en = 1'b1;
        endcase
    end

    assert_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (sleep_mode == 2'b01 && loss.carrier) |-> power_en);
    assert_sleep_after_loss_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(power_en) && sleep_mode == 2'b01 && $past(sleep_mode) == 2'b01)
        |-> (!loss.carrier && !$past(loss.carrier)));
endmodule

// File: rtl/eqs_gate.sv
module eqs_gate #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              power_en,
    input  logic              mute,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst)                   out_q <= '0;
        else if (!power_en || mute) out_q <= '0;
        else                       out_q <= data_in;
    end

    assign data_out = out_q;

    assert_sleep_over_mute_R10: assert property (@(posedge clk) disable iff (rst)
        (|data_out) |-> ($past(power_en) && !$past(mute)));
endmodule

// File: rtl/eqs_ctrl.sv
module eqs_ctrl
    import eqs_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LOSS_DELAY = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sleep_mode,
    input  logic              mute,
    input  logic              carrier_raw,
    input  logic [DATA_W-1:0] data_in,
    output logic              eq_power_en,
    output logic [DATA_W-1:0] data_out,
    output logic              cd_n,
    output logic              carrier_status
);
    logic        carrier_s;
    logic        loss_expired;
    loss_state_t loss;

    eqs_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (carrier_raw),
        .sync_out (carrier_s)
    );

    eqs_loss_timer #(.LOSS_DELAY(LOSS_DELAY)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .carrier (carrier_s),
        .expired (loss_expired)
    );

    assign loss.carrier = carrier_s;
    assign loss.expired = loss_expired;

    eqs_power u_power (
        .clk        (clk),
        .rst        (rst),
        .sleep_mode (sleep_mode),
        .loss       (loss),
        .power_en   (eq_power_en)
    );

    eqs_gate #(.DATA_W(DATA_W)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .power_en (eq_power_en),
        .mute     (mute),
        .data_in  (data_in),
        .data_out (data_out)
    );

    assign carrier_status = carrier_s;
    assign cd_n           = ~carrier_s;

    assert_never_sleep_R2: assert property (@(posedge clk) disable iff (rst)
        (sleep_mode == 2'b00) |-> eq_power_en);
    assert_reserved_on_R3: assert property (@(posedge clk) disable iff (rst)
        (sleep_mode == 2'b11) |-> eq_power_en);
    assert_force_off_R4: assert property (@(posedge clk) disable iff (rst)
        (sleep_mode == 2'b10) |-> !eq_power_en);
    assert_cd_polarity_R8: assert property (@(posedge clk) disable iff (rst)
        cd_n != carrier_status);
endmodule

// File: tb/eqs_ctrl_tb.sv
module eqs_ctrl_tb;
    localparam int DW  = 8;
    localparam int DLY = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    sleep_mode;
    logic          mute;
    logic          carrier_raw;
    logic [DW-1:0] data_in;
    logic          eq_power_en;
    logic [DW-1:0] data_out;
    logic          cd_n;
    logic          carrier_status;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    eqs_ctrl #(.DATA_W(DW), .LOSS_DELAY(DLY)) u_dut (
        .clk(clk), .rst(rst), .sleep_mode(sleep_mode), .mute(mute),
        .carrier_raw(carrier_raw), .data_in(data_in),
        .eq_power_en(eq_power_en), .data_out(data_out),
        .cd_n(cd_n), .carrier_status(carrier_status)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        bit stayed;
        rst = 1'b1; sleep_mode = 2'b01; mute = 1'b0; carrier_raw = 1'b0; data_in = 8'h5A;
        step(3);
        rst = 1'b0;
        // R1: reset state, still visible before the next edge
        check(eq_power_en == 1'b1, "R1 power", int'(eq_power_en), 1);
        check(data_out == '0, "R1 data", int'(data_out), 0);
        check(cd_n == 1'b1, "R1 cd_n", int'(cd_n), 1);
        check(carrier_status == 1'b0, "R1 status", int'(carrier_status), 0);

        // Steady-state sweep: R2 R3 R4 R9 R10
        for (int m = 0; m < 4; m++) begin
            for (int mu = 0; mu < 2; mu++) begin
                for (int c = 0; c < 2; c++) begin
                    int exp_p;
                    int exp_d;
                    sleep_mode  = m[1:0];
                    mute        = mu[0];
                    carrier_raw = c[0];
                    data_in     = 8'((m * 64 + mu * 16 + c * 5 + 17) ^ 8'hC3);
                    step(DLY + 4);
                    exp_p = (m == 2) ? 0 : (m == 1) ? c : 1;
                    exp_d = (exp_p == 1 && mu == 0) ? int'(data_in) : 0;
                    check(int'(eq_power_en) == exp_p,
                          (m == 0) ? "R2 power" : (m == 3) ? "R3 power" :
                          (m == 2) ? "R4 power" : "R5 power steady",
                          int'(eq_power_en), exp_p);
                    check(int'(data_out) == exp_d,
                          (exp_p == 0) ? "R10 data" : "R9 data",
                          int'(data_out), exp_d);
                    check(int'(carrier_status) == c && int'(cd_n) == 1 - c,
                          "R8 status", int'(carrier_status), c);
                end
            end
        end

        // R4: forced off is immediate, and R2 restore is immediate
        sleep_mode = 2'b00; carrier_raw = 1'b1; mute = 1'b0;
        step(4);
        sleep_mode = 2'b10; #1;
        check(eq_power_en == 1'b0, "R4 immediate", int'(eq_power_en), 0);
        sleep_mode = 2'b00; #1;
        check(eq_power_en == 1'b1, "R2 immediate", int'(eq_power_en), 1);

        // R5: exact power-down delay
        sleep_mode = 2'b01; carrier_raw = 1'b1;
        step(DLY + 4);
        carrier_raw = 1'b0;
        n = 0;
        while (eq_power_en && n < 4 * DLY) begin
            step(1);
            n++;
        end
        check(n == DLY + 2, "R5 delay", n, DLY + 2);

        // R7: wake-up latency
        carrier_raw = 1'b1;
        n = 0;
        while (!eq_power_en && n < 20) begin
            step(1);
            n++;
        end
        check(n == 2, "R7 wake", n, 2);

        // R6: carrier pulse during the wait restarts the timer
        step(DLY + 4);
        carrier_raw = 1'b0;
        stayed = 1'b1;
        for (int k = 0; k < DLY - 2; k++) begin
            step(1);
            if (!eq_power_en) stayed = 1'b0;
        end
        carrier_raw = 1'b1;
        step(1);
        if (!eq_power_en) stayed = 1'b0;
        carrier_raw = 1'b0;
        n = 0;
        while (eq_power_en && n < 4 * DLY) begin
            step(1);
            n++;
        end
        check(stayed, "R6 stayed powered", int'(stayed), 1);
        check(n == DLY + 2, "R6 restart", n, DLY + 2);

        // R8: two-edge synchronizer latency and polarity
        carrier_raw = 1'b1;
        step(1);
        check(carrier_status == 1'b0, "R8 one edge", int'(carrier_status), 0);
        step(1);
        check(carrier_status == 1'b1 && cd_n == 1'b0, "R8 two edges", int'(carrier_status), 1);
        carrier_raw = 1'b0;
        step(2);
        check(carrier_status == 1'b0 && cd_n == 1'b1, "R8 loss", int'(cd_n), 1);

        // R10: asleep with mute 0 and mute 1 on a changing pattern
        sleep_mode = 2'b10;
        for (int i = 0; i < 4; i++) begin
            mute = i[0];
            data_in = 8'(8'h81 + i * 29);
            step(1);
            check(data_out == '0, "R10 asleep", int'(data_out), 0);
        end

        // R9: per-cycle pass and mute while powered
        sleep_mode = 2'b00;
        for (int i = 0; i < 6; i++) begin
            int e;
            mute = (i % 3 == 2);
            data_in = 8'(8'h0F + i * 41);
            step(1);
            e = mute ? 0 : int'(data_in);
            check(int'(data_out) == e, "R9 cycle", int'(data_out), e);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule